// File: doc/BRIEF.md
# Flash Suspend/Resume Command Filter

This block sits between the bus write port of a flash command interface and its program/erase controller. Each write strobe carries a one-byte opcode and a block index. The filter sorts the opcode into a command class. It decides from its operating state whether the command is legal, and then it starts, pauses or resumes the controller. Five states matter: idle, programming, erasing, program-suspended and erase-suspended. A sixth state covers a program running while an erase is paused.

The status byte is assembled from the state and from sticky error flags. Those flags are set by rejected commands, by failed controller operations and by accesses to the block whose erase is paused. They are removed only by the clear command.

Top module: `flash_susp_filter`

## Requirements
- R1: While reset is low and after it rises, status reads 0x80 (idle). Reset during a suspension abandons it, so a later resume (0xD0) is rejected.
- R2: Opcodes by class: reads 0xFF, 0x70, 0x90, 0x98; clear 0x50; program 0x40, 0x30, 0x56, 0xC0; erase 0x20; lock 0x60; suspend 0xB0; resume 0xD0. All other opcodes are illegal. When idle, reads, clear, program, erase and lock are accepted. An accepted program or erase pulses ctl_start in the write cycle, with ctl_erase high only for erase.
- R3: While programming or erasing, status bit 7 is 0. Only reads, clear and suspend are accepted. An accepted suspend pulses ctl_pause in the write cycle and enters the matching suspended state.
- R4: While a program is suspended, status bits 7 and 2 are 1. Only reads and resume are accepted.
- R5: While an erase is suspended, status bits 7 and 6 are 1. Reads, resume, program-class and lock commands are accepted. A program starts a nested program, during which bit 7 is 0 and bit 6 stays 1. Its completion returns to erase-suspended.
- R6: An accepted resume pulses ctl_resume and returns to the paused operation. The next ctl_done ends it in idle.
- R7: A rejected write sets status bit 4. It leaves the state unchanged and pulses no controller output.
- R8: While an erase is suspended, a program aimed at the erasing block is rejected and also sets status bit 1. A read strobe (rd_stb) at that block sets bit 1. Accesses to other blocks set nothing.
- R9: An accepted clear (0x50) resets status bits 1, 3, 4 and 5. It leaves bits 7, 6 and 2 unchanged. Bit 3 always reads 0 and bit 0 always reads 0.
- R10: Error bits persist through new program and erase commands and through their completion.
- R11: ctl_done with ctl_fail ends a program with bit 4 set, or an erase with bit 5 set. If ctl_done arrives in a running state together with a write, the write is discarded without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Bus write strobe |
| wr_data | input | 8 | Command opcode |
| wr_blk | input | BLK_W | Block index of the write |
| rd_stb | input | 1 | Array read strobe |
| rd_blk | input | BLK_W | Block index of the read |
| ctl_done | input | 1 | Controller finished the running operation |
| ctl_fail | input | 1 | Qualifies ctl_done as failed |
| ctl_start | output | 1 | Start program or erase |
| ctl_erase | output | 1 | The started operation is an erase |
| ctl_pause | output | 1 | Pause the running operation |
| ctl_resume | output | 1 | Restart the paused operation |
| status | output | 8 | Status byte |

## Verification
The assertions hold on every cycle for these properties:
- A rejected write sets bit 4 and leaves the state unchanged.
- Sticky flags survive until an accepted clear, and that clear empties them.
- A pause is only issued while the controller runs, and a resume leaves the ready bit low.
- A nested program never targets the block whose erase is paused.

The bench exercises the per-state legality of all 256 opcodes, which the assertions cannot enumerate. It also covers the completion and failure paths, reset during a suspension, and the collision of a write with a completion.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

   localparam logic [7:0] OP_SUSP   = 8'hB0;
   localparam logic [7:0] OP_RESUME = 8'hD0;
   localparam logic [7:0] OP_CLR    = 8'h50;
   localparam logic [7:0] OP_RDARR  = 8'hFF;
   localparam logic [7:0] OP_RDSTAT = 8'h70;
   localparam logic [7:0] OP_RDSIG  = 8'h90;
   localparam logic [7:0] OP_RDQRY  = 8'h98;
   localparam logic [7:0] OP_PGM1   = 8'h40;
   localparam logic [7:0] OP_PGM2   = 8'h30;
   localparam logic [7:0] OP_PGM4   = 8'h56;
   localparam logic [7:0] OP_PGMPR  = 8'hC0;
   localparam logic [7:0] OP_ERASE  = 8'h20;
   localparam logic [7:0] OP_LOCK   = 8'h60;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PROG, ST_ERASE, ST_PSUSP, ST_ESUSP, ST_ESPROG
   } fsf_state_e;

   typedef enum logic [2:0] {
      CL_BAD, CL_READ, CL_CLR, CL_SUSP, CL_RESUME, CL_PROG, CL_ERASE, CL_LOCK
   } fsf_class_e;

   // sticky flag slots, mapped onto status bits 1, 3, 4, 5
   localparam int unsigned FLG_N   = 4;
   localparam int unsigned FLG_BLK = 0;
   localparam int unsigned FLG_RSV = 1;
   localparam int unsigned FLG_PGM = 2;
   localparam int unsigned FLG_ERS = 3;

endpackage

// File: rtl/fsf_decode.sv
module fsf_decode
   import fsf_pkg::*;
(
   input  logic [7:0] op,
   output fsf_class_e cls
);

   always_comb begin
      case (op)
         OP_RDARR, OP_RDSTAT, OP_RDSIG, OP_RDQRY: cls = CL_READ;
         OP_CLR:                                 cls = CL_CLR;
         OP_SUSP:                                cls = CL_SUSP;
         OP_RESUME:                              cls = CL_RESUME;
         OP_PGM1, OP_PGM2, OP_PGM4, OP_PGMPR:    cls = CL_PROG;
         OP_ERASE:                               cls = CL_ERASE;
         OP_LOCK:                                cls = CL_LOCK;
         default:                                cls = CL_BAD;
      endcase
   end

endmodule

// File: rtl/fsf_legal.sv
module fsf_legal
   import fsf_pkg::*;
#(
   parameter bit ESUSP_LOCK = 1'b1
)(
   input  fsf_state_e state,
   input  fsf_class_e cls,
   input  logic       blk_hit,
   output logic       ok
);

   logic lock_ok;

   generate
      if (ESUSP_LOCK) begin : g_lock_on
         assign lock_ok = 1'b1;
      end else begin : g_lock_off
         assign lock_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      case (state)
         ST_IDLE:
            ok = (cls == CL_READ) || (cls == CL_CLR) || (cls == CL_PROG) ||
                 (cls == CL_ERASE) || (cls == CL_LOCK);
         ST_PROG, ST_ERASE:
            ok = (cls == CL_READ) || (cls == CL_CLR) || (cls == CL_SUSP);
         ST_PSUSP:
            ok = (cls == CL_READ) || (cls == CL_RESUME);
         ST_ESUSP:
            ok = (cls == CL_READ) || (cls == CL_RESUME) ||
                 ((cls == CL_PROG) && !blk_hit) ||
                 ((cls == CL_LOCK) && lock_ok);
         ST_ESPROG:
            ok = (cls == CL_READ) || (cls == CL_CLR);
         default:
            ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/fsf_sticky.sv
module fsf_sticky #(
   parameter int unsigned NB = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set,
   input  logic          clr,
   output logic [NB-1:0] q
);

   generate
      if (NB < 1) begin : g_bad_nb
         $error("fsf_sticky: NB must be at least 1");
      end
      for (genvar i = 0; i < NB; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr)    q[i] <= 1'b0;
         end

         // R10: a flag holds until a clear arrives
         a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            q[i] && !clr |=> q[i]);
         // R9: a clear with no competing set empties the flag
         a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
            clr && !set[i] |=> !q[i]);
      end
   endgenerate

endmodule

// File: rtl/flash_susp_filter.sv
module flash_susp_filter
   import fsf_pkg::*;
#(
   parameter int unsigned BLK_W      = 4,
   parameter bit          ESUSP_LOCK = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [7:0]       wr_data,
   input  logic [BLK_W-1:0] wr_blk,
   input  logic             rd_stb,
   input  logic [BLK_W-1:0] rd_blk,
   input  logic             ctl_done,
   input  logic             ctl_fail,
   output logic             ctl_start,
   output logic             ctl_erase,
   output logic             ctl_pause,
   output logic             ctl_resume,
   output logic [7:0]       status
);

   localparam int unsigned BLK_MAX = 16;

   generate
      if (BLK_W < 1 || BLK_W > BLK_MAX) begin : g_bad_blk
         $error("flash_susp_filter: BLK_W out of range");
      end
   endgenerate

   fsf_state_e       state, state_nx;
   fsf_class_e       cls;
   logic [BLK_W-1:0] eblk;
   logic             blk_hit, ok, running, done_eff, wr_eval, go, rej, esusp_any;
   logic [FLG_N-1:0] flg_set, flg;

   fsf_decode u_dec (.op(wr_data), .cls(cls));

   fsf_legal #(.ESUSP_LOCK(ESUSP_LOCK)) u_legal (
      .state(state), .cls(cls), .blk_hit(blk_hit), .ok(ok));

   assign blk_hit   = (wr_blk == eblk);
   assign running   = (state == ST_PROG) || (state == ST_ERASE) || (state == ST_ESPROG);
   assign esusp_any = (state == ST_ESUSP) || (state == ST_ESPROG);
   assign done_eff  = ctl_done && running;
   assign wr_eval   = wr_stb && !done_eff;
   assign go        = wr_eval && ok;
   assign rej       = wr_eval && !ok;

   assign ctl_start  = go && ((cls == CL_PROG) || (cls == CL_ERASE));
   assign ctl_erase  = (cls == CL_ERASE);
   assign ctl_pause  = go && (cls == CL_SUSP);
   assign ctl_resume = go && (cls == CL_RESUME);

   always_comb begin
      state_nx = state;
      if (done_eff) begin
         state_nx = (state == ST_ESPROG) ? ST_ESUSP : ST_IDLE;
      end else if (go) begin
         case (state)
            ST_IDLE:
               if (cls == CL_PROG)       state_nx = ST_PROG;
               else if (cls == CL_ERASE) state_nx = ST_ERASE;
            ST_PROG:  if (cls == CL_SUSP)   state_nx = ST_PSUSP;
            ST_ERASE: if (cls == CL_SUSP)   state_nx = ST_ESUSP;
            ST_PSUSP: if (cls == CL_RESUME) state_nx = ST_PROG;
            ST_ESUSP:
               if (cls == CL_RESUME)     state_nx = ST_ERASE;
               else if (cls == CL_PROG)  state_nx = ST_ESPROG;
            default: state_nx = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         eblk  <= '0;
      end else begin
         state <= state_nx;
         if (ctl_start && ctl_erase) eblk <= wr_blk;
      end
   end

   always_comb begin
      flg_set          = '0;
      flg_set[FLG_BLK] = (rej && (state == ST_ESUSP) && (cls == CL_PROG) && blk_hit) ||
                         (rd_stb && esusp_any && (rd_blk == eblk));
      flg_set[FLG_RSV] = 1'b0;
      flg_set[FLG_PGM] = rej || (done_eff && ctl_fail && (state != ST_ERASE));
      flg_set[FLG_ERS] = done_eff && ctl_fail && (state == ST_ERASE);
   end

   fsf_sticky #(.NB(FLG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flg_set),
      .clr(go && (cls == CL_CLR)), .q(flg));

   assign status = {
      (state == ST_IDLE) || (state == ST_PSUSP) || (state == ST_ESUSP),
      esusp_any,
      flg[FLG_ERS],
      flg[FLG_PGM],
      flg[FLG_RSV],
      (state == ST_PSUSP),
      flg[FLG_BLK],
      1'b0 };

   // R7: rejection raises the command-error bit and freezes the state
   a_r7_reject_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      rej |=> status[4] && $stable(state));
   // R3: pause only while the controller is running
   a_r3_pause_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_pause |-> !status[7]);
   // R6: resume hands the array back to the controller
   a_r6_resume_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_resume |=> !status[7]);
   // R8: no nested program lands on the paused erase block
   a_r8_no_prog_on_eblk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_start && (state == ST_ESUSP) |-> (wr_blk != eblk));

endmodule

// File: tb/tb_flash_susp_filter.sv
module tb_flash_susp_filter;

   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [7:0]    wr_data = 8'h00;
   logic [BW-1:0] wr_blk = '0;
   logic          rd_stb = 1'b0;
   logic [BW-1:0] rd_blk = '0;
   logic          ctl_done = 1'b0;
   logic          ctl_fail = 1'b0;
   logic          ctl_start, ctl_erase, ctl_pause, ctl_resume;
   logic [7:0]    status;

   int checks = 0;
   int errors = 0;
   logic s_start, s_pause, s_resume;

   always #2 clk = ~clk;

   flash_susp_filter #(.BLK_W(BW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .wr_blk(wr_blk),
      .rd_stb(rd_stb), .rd_blk(rd_blk), .ctl_done(ctl_done), .ctl_fail(ctl_fail),
      .ctl_start(ctl_start), .ctl_erase(ctl_erase), .ctl_pause(ctl_pause),
      .ctl_resume(ctl_resume), .status(status));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic wr(input logic [7:0] op, input logic [BW-1:0] b);
      @(negedge clk);
      wr_stb = 1'b1; wr_data = op; wr_blk = b;
      #1;
      s_start = ctl_start; s_pause = ctl_pause; s_resume = ctl_resume;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic done(input logic f);
      @(negedge clk); ctl_done = 1'b1; ctl_fail = f;
      @(negedge clk); ctl_done = 1'b0; ctl_fail = 1'b0;
   endtask

   task automatic rd(input logic [BW-1:0] b);
      @(negedge clk); rd_stb = 1'b1; rd_blk = b;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   // command classes: 0 bad 1 read 2 clear 3 suspend 4 resume 5 program 6 erase 7 lock
   function automatic int cls_of(input int op);
      case (op)
         8'hFF, 8'h70, 8'h90, 8'h98: return 1;
         8'h50: return 2;
         8'hB0: return 3;
         8'hD0: return 4;
         8'h40, 8'h30, 8'h56, 8'hC0: return 5;
         8'h20: return 6;
         8'h60: return 7;
         default: return 0;
      endcase
   endfunction

   // states: 0 idle 1 prog 2 erase 3 prog-susp 4 erase-susp 5 nested prog
   function automatic bit legal(input int st, input int c);
      case (st)
         0: return c == 1 || c == 2 || c == 5 || c == 6 || c == 7;
         1, 2: return c == 1 || c == 2 || c == 3;
         3: return c == 1 || c == 4;
         4: return c == 1 || c == 4 || c == 5 || c == 7;
         default: return c == 1 || c == 2;
      endcase
   endfunction

   function automatic int next_st(input int st, input int c);
      if (st == 0 && c == 5) return 1;
      if (st == 0 && c == 6) return 2;
      if (st == 1 && c == 3) return 3;
      if (st == 2 && c == 3) return 4;
      if (st == 3 && c == 4) return 1;
      if (st == 4 && c == 4) return 2;
      if (st == 4 && c == 5) return 5;
      return st;
   endfunction

   function automatic int st_stat(input int st);
      case (st)
         0: return 8'h80;
         3: return 8'h84;
         4: return 8'hC0;
         5: return 8'h40;
         default: return 8'h00;
      endcase
   endfunction

   task automatic goto_state(input int st);
      do_reset();
      case (st)
         1: wr(8'h40, 4'd5);
         2: wr(8'h20, 4'd3);
         3: begin wr(8'h40, 4'd5); wr(8'hB0, 4'd0); end
         4: begin wr(8'h20, 4'd3); wr(8'hB0, 4'd0); end
         5: begin wr(8'h20, 4'd3); wr(8'hB0, 4'd0); wr(8'h40, 4'd5); end
         default: ;
      endcase
   endtask

   initial begin : watchdog
      #700000;
      errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      string tag;
      int c, exp_s, ns;
      bit a;
      // R1 reset state
      #1; chk("R1 status in reset", status, 8'h80);
      do_reset();
      chk("R1 status after reset", status, 8'h80);

      // exhaustive opcode sweep across every state: R2 R3 R4 R5 R7
      for (int st = 0; st < 6; st++) begin
         for (int op = 0; op < 256; op++) begin
            goto_state(st);
            wr(op[7:0], 4'd5);
            c = cls_of(op);
            a = legal(st, c);
            ns = a ? next_st(st, c) : st;
            exp_s = st_stat(ns) | (a ? 0 : 8'h10);
            case (st)
               0: tag = "R2 idle";
               1, 2: tag = "R3 running";
               3: tag = "R4 prog-suspended";
               4: tag = "R5 erase-suspended";
               default: tag = "R5 nested";
            endcase
            if (!a) tag = {tag, " R7 reject"};
            chk(tag, status, exp_s);
            chk({tag, " ctl_start"}, s_start, int'(a && (c == 5 || c == 6)));
         end
      end

      // R3 suspend pulses ctl_pause
      goto_state(1); wr(8'hB0, 4'd0);
      chk("R3 ctl_pause", s_pause, 1);

      // R8 program at erasing block
      goto_state(4); wr(8'h40, 4'd3);
      chk("R8 prog on erase block", status, 8'hD2);
      chk("R8 no start", s_start, 0);
      // R9 clear illegal while suspended, then legal once running
      wr(8'h50, 4'd0);
      chk("R9 clear rejected in suspend", status, 8'hD2);
      wr(8'hD0, 4'd0);
      chk("R6 resume pulse", s_resume, 1);
      chk("R6 resumed erase keeps flags", status, 8'h12);
      wr(8'h50, 4'd0);
      chk("R9 clear in erase", status, 8'h00);
      done(1'b1);
      chk("R11 erase fail", status, 8'hA0);
      wr(8'h40, 4'd1);
      chk("R10 flag kept on new program", status, 8'h20);
      done(1'b0);
      chk("R10 flag kept after completion", status, 8'hA0);

      // R8 read strobes
      goto_state(4);
      rd(4'd4);
      chk("R8 read other block", status, 8'hC0);
      rd(4'd3);
      chk("R8 read erase block", status, 8'hC2);

      // R5 nested program and R6 resume to completion
      goto_state(4);
      wr(8'h40, 4'd5);
      chk("R5 nested start", s_start, 1);
      done(1'b0);
      chk("R5 nested done back to suspend", status, 8'hC0);
      wr(8'hD0, 4'd0);
      chk("R6 resume", status, 8'h00);
      done(1'b0);
      chk("R6 erase completes", status, 8'h80);

      // R11 program fail
      goto_state(1); done(1'b1);
      chk("R11 program fail", status, 8'h90);

      // R1 reset while suspended
      goto_state(3);
      chk("R4 suspended status", status, 8'h84);
      do_reset();
      chk("R1 reset aborts suspend", status, 8'h80);
      wr(8'hD0, 4'd0);
      chk("R1 resume after reset rejected", status, 8'h90);

      // R11 completion collides with a write
      goto_state(1);
      @(negedge clk); wr_stb = 1'b1; wr_data = 8'hB0; ctl_done = 1'b1;
      @(negedge clk); wr_stb = 1'b0; ctl_done = 1'b0;
      chk("R11 done wins over write", status, 8'h80);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule